// File: doc/BRIEF.md
# Binary64 Predicate Comparator

This block compares two IEEE-754 binary64 operands under one of 32 selectable predicates and returns a single boolean answer. It first sorts the operand pair into one of four relation classes: A greater than B, A less than B, A equal to B, or unordered. It then reads the answer for that class out of the chosen predicate. Alongside the answer it raises an invalid-operation flag and a denormal-operand flag. Nothing is masked or trapped here; the caller decides what to do with the flags.

The block is purely combinational and holds no state. A vector unit places one copy per lane. It feeds each copy the lane's operand pair and the shared predicate byte. It then widens or collects the boolean results as its destination format needs.

Top module: `fp64_pred_cmp`

## Requirements
- R1: Only the low five bits of `pred_imm` select the predicate; bits 7:5 have no effect on `result`, `invalid` or `denormal`.
- R2: A value with an all-ones exponent (bits 62:52) and a nonzero fraction (bits 51:0) is a NaN. If either operand is a NaN the pair is unordered, and `result` is the predicate's unordered outcome.
- R3: For non-NaN operands the relation follows real-number order. +0 and -0 are equal, a negative value with a larger magnitude is smaller, and equal bit patterns are equal.
- R4: For predicate codes 0 to 15, the outcomes listed as (greater, less, equal, unordered) come from a base set selected by code bits 1:0: 0 gives (0,0,1,0), 1 gives (0,1,0,0), 2 gives (0,1,1,0) and 3 gives (0,0,0,1). Code bit 3 then inverts the unordered outcome, and code bit 2 then inverts all four outcomes. Code 15 is therefore always true and code 11 always false.
- R5: Code bit 4 does not change the truth outcomes: codes 16 to 31 answer exactly as codes 0 to 15.
- R6: A predicate is signaling when code bits 0, 1 and 4 have odd parity. The signaling codes are 1, 2, 5, 6, 9, 10, 13, 14, 16, 19, 20, 23, 24, 27, 28 and 31; all other codes are quiet.
- R7: `invalid` is 1 whenever either operand is a signaling NaN (fraction bit 51 clear), for every predicate.
- R8: When the only NaNs present are quiet NaNs (fraction bit 51 set), `invalid` equals 1 for signaling predicates and 0 for quiet ones.
- R9: `invalid` is 0 when neither operand is a NaN.
- R10: `denormal` is 1 exactly when either operand has a zero exponent and a nonzero fraction.
- R11: Infinities order as the extremes: -inf is below every finite value, +inf is above every finite value, and each infinity equals itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 64 | First operand (A), binary64 |
| opnd_b | input | 64 | Second operand (B), binary64 |
| pred_imm | input | 8 | Predicate byte; low 5 bits pick the predicate |
| result | output | 1 | Predicate outcome for the pair |
| invalid | output | 1 | Invalid-operation flag |
| denormal | output | 1 | Subnormal operand present |

## Verification
All three outputs are combinational and due in the same cycle as the operands and predicate byte that produce them; no register lies on any path. The bench changes the inputs just after a falling clock edge and samples one nanosecond later, well before the next rising edge. Every sample therefore reflects only the current stimulus. A sweep crosses fifteen representative operands (both zeros, unit and double values of each sign, subnormals, infinities, the largest finite value, quiet and signaling NaNs) against all 32 predicates, with the reserved bits rotating. Expected values come from real-number comparison of the operands and from literal truth and signaling tables written in the bench.

// File: rtl/fp64_cmp_pkg.sv
package fp64_cmp_pkg;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_qnan;
    logic is_zero;
    logic is_sub;
  } opclass_t;

  typedef struct packed {
    logic on_gt;
    logic on_lt;
    logic on_eq;
    logic on_un;
  } truth_t;

  // Base outcome set chosen by the two low code bits.
  function automatic truth_t base_truth(input logic [1:0] sel);
    truth_t t;
    case (sel)
      2'd0:    t = '{on_gt: 1'b0, on_lt: 1'b0, on_eq: 1'b1, on_un: 1'b0};
      2'd1:    t = '{on_gt: 1'b0, on_lt: 1'b1, on_eq: 1'b0, on_un: 1'b0};
      2'd2:    t = '{on_gt: 1'b0, on_lt: 1'b1, on_eq: 1'b1, on_un: 1'b0};
      default: t = '{on_gt: 1'b0, on_lt: 1'b0, on_eq: 1'b0, on_un: 1'b1};
    endcase
    return t;
  endfunction

  // Full outcome set: bit 3 flips the unordered answer, bit 2 inverts all.
  function automatic truth_t pred_truth(input logic [4:0] code);
    truth_t t;
    t = base_truth(code[1:0]);
    if (code[3]) t.on_un = ~t.on_un;
    if (code[2]) t = truth_t'(~t);
    return t;
  endfunction

  // Signaling predicates raise invalid on a quiet NaN.
  function automatic logic pred_signals(input logic [4:0] code);
    return code[4] ^ code[1] ^ code[0];
  endfunction

  function automatic logic pick_outcome(input truth_t t, input rel_e r);
    logic o;
    case (r)
      REL_GT:  o = t.on_gt;
      REL_LT:  o = t.on_lt;
      REL_EQ:  o = t.on_eq;
      default: o = t.on_un;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/fp64_operand_class.sv
module fp64_operand_class
  import fp64_cmp_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] val,
  output opclass_t              cls
);
  localparam int unsigned QUIET_POS = FRAC_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;
  logic              exp_min;
  logic              frac_nz;

  assign exp_f   = val[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f  = val[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    cls.is_nan  = exp_max & frac_nz;
    cls.is_qnan = exp_max & frac_nz & frac_f[QUIET_POS];
    cls.is_snan = exp_max & frac_nz & ~frac_f[QUIET_POS];
    cls.is_zero = exp_min & ~frac_nz;
    cls.is_sub  = exp_min & frac_nz;
  end
endmodule

// File: rtl/fp64_order.sv
module fp64_order
  import fp64_cmp_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] val_a,
  input  logic [EXP_W+FRAC_W:0] val_b,
  input  opclass_t              cls_a,
  input  opclass_t              cls_b,
  output rel_e                  rel
);
  localparam int unsigned SIGN_POS = EXP_W + FRAC_W;

  logic [SIGN_POS-1:0] mag_a;
  logic [SIGN_POS-1:0] mag_b;
  logic                sign_a;
  logic                sign_b;
  logic                mag_gt;
  logic                same_bits;

  assign mag_a     = val_a[SIGN_POS-1:0];
  assign mag_b     = val_b[SIGN_POS-1:0];
  assign sign_a    = val_a[SIGN_POS];
  assign sign_b    = val_b[SIGN_POS];
  assign mag_gt    = mag_a > mag_b;
  assign same_bits = val_a == val_b;

  always_comb begin
    if (cls_a.is_nan || cls_b.is_nan)       rel = REL_UN;
    else if (cls_a.is_zero && cls_b.is_zero) rel = REL_EQ;
    else if (same_bits)                     rel = REL_EQ;
    else if (sign_a != sign_b)              rel = sign_a ? REL_LT : REL_GT;
    else if (!sign_a)                       rel = mag_gt ? REL_GT : REL_LT;
    else                                    rel = mag_gt ? REL_LT : REL_GT;
  end
endmodule

// File: rtl/fp64_pred_decode.sv
module fp64_pred_decode
  import fp64_cmp_pkg::*;
#(
  parameter int unsigned PRED_W = 5
) (
  input  logic [PRED_W-1:0] code,
  output truth_t            truth,
  output logic              sig_qnan
);
  logic [4:0] code5;

  generate
    if (PRED_W >= 5) begin : g_trim
      assign code5 = code[4:0];
      if (PRED_W > 5) begin : g_extra
        logic unused_code_hi;
        assign unused_code_hi = ^code[PRED_W-1:5];
      end
    end else begin : g_pad
      assign code5 = {{(5-PRED_W){1'b0}}, code};
    end
  endgenerate

  assign truth    = pred_truth(code5);
  assign sig_qnan = pred_signals(code5);
endmodule

// File: rtl/fp64_pred_cmp.sv
module fp64_pred_cmp
  import fp64_cmp_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned PRED_W = 5
) (
  input  logic [EXP_W+FRAC_W:0] opnd_a,
  input  logic [EXP_W+FRAC_W:0] opnd_b,
  input  logic [IMM_W-1:0]      pred_imm,
  output logic                  result,
  output logic                  invalid,
  output logic                  denormal
);
  localparam int unsigned FP_W   = EXP_W + FRAC_W + 1;
  localparam int unsigned N_OPND = 2;

  logic [FP_W-1:0] opnd_v [N_OPND];
  opclass_t        cls_v  [N_OPND];
  opclass_t        cls_a;
  opclass_t        cls_b;
  rel_e            rel;
  truth_t          truth;
  logic            sig_qnan;
  logic            snan_seen;
  logic            qnan_seen;

  assign opnd_v[0] = opnd_a;
  assign opnd_v[1] = opnd_b;

  generate
    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
      fp64_operand_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .val (opnd_v[gi]),
        .cls (cls_v[gi])
      );
    end
    if (IMM_W > PRED_W) begin : g_resv
      logic unused_resv_bits;
      assign unused_resv_bits = ^pred_imm[IMM_W-1:PRED_W];
    end
  endgenerate

  assign cls_a = cls_v[0];
  assign cls_b = cls_v[1];

  fp64_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
    .val_a (opnd_a),
    .val_b (opnd_b),
    .cls_a (cls_a),
    .cls_b (cls_b),
    .rel   (rel)
  );

  fp64_pred_decode #(.PRED_W(PRED_W)) u_dec (
    .code     (pred_imm[PRED_W-1:0]),
    .truth    (truth),
    .sig_qnan (sig_qnan)
  );

  assign snan_seen = cls_a.is_snan | cls_b.is_snan;
  assign qnan_seen = cls_a.is_qnan | cls_b.is_qnan;

  assign result   = pick_outcome(truth, rel);
  assign invalid  = snan_seen | (qnan_seen & sig_qnan);
  assign denormal = cls_a.is_sub | cls_b.is_sub;
endmodule

// File: rtl/fp64_pred_cmp_chk.sv
module fp64_pred_cmp_chk
  import fp64_cmp_pkg::*;
(
  input logic [63:0] opnd_a,
  input logic [63:0] opnd_b,
  input logic [7:0]  pred_imm,
  input logic        result,
  input logic        invalid,
  input logic        denormal,
  input opclass_t    cls_a,
  input opclass_t    cls_b,
  input rel_e        rel,
  input truth_t      truth,
  input logic        sig_qnan
);
  logic any_nan;
  logic any_snan;
  logic any_qnan;
  assign any_nan  = cls_a.is_nan | cls_b.is_nan;
  assign any_snan = cls_a.is_snan | cls_b.is_snan;
  assign any_qnan = cls_a.is_qnan | cls_b.is_qnan;

  always_comb begin
    if (any_nan)
      p_nan_unordered_r2: assert (rel == REL_UN) else $error("R2 NaN not unordered");
    if (!any_nan)
      p_ordered_rel_r3: assert (rel != REL_UN) else $error("R3 ordered pair unordered");
    if (cls_a.is_zero && cls_b.is_zero)
      p_zeros_equal_r3: assert (rel == REL_EQ) else $error("R3 zeros not equal");
    if (rel == REL_UN)
      p_un_outcome_r2: assert (result == truth.on_un) else $error("R2 unordered outcome");
    if (rel == REL_GT)
      p_gt_outcome_r4: assert (result == truth.on_gt) else $error("R4 gt outcome");
    if (rel == REL_LT)
      p_lt_outcome_r4: assert (result == truth.on_lt) else $error("R4 lt outcome");
    if (rel == REL_EQ)
      p_eq_outcome_r4: assert (result == truth.on_eq) else $error("R4 eq outcome");
    if (pred_imm[3:0] == 4'hF)
      p_always_true_r4: assert (result) else $error("R4 true predicate low");
    if (pred_imm[3:0] == 4'hB)
      p_always_false_r4: assert (!result) else $error("R4 false predicate high");
    if (any_snan)
      p_snan_invalid_r7: assert (invalid) else $error("R7 SNaN without invalid");
    if (any_qnan && !any_snan)
      p_qnan_rule_r8: assert (invalid == sig_qnan) else $error("R8 QNaN invalid rule");
    if (!any_nan)
      p_no_nan_quiet_r9: assert (!invalid) else $error("R9 invalid without NaN");
    if (cls_a.is_sub || cls_b.is_sub)
      p_sub_flag_r10: assert (denormal) else $error("R10 subnormal missed");
    if (denormal)
      p_flag_exp_r10: assert (opnd_a[62:52] == 11'd0 || opnd_b[62:52] == 11'd0)
        else $error("R10 flag without zero exponent");
  end
endmodule

bind fp64_pred_cmp fp64_pred_cmp_chk u_chk (
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .pred_imm (pred_imm),
  .result   (result),
  .invalid  (invalid),
  .denormal (denormal),
  .cls_a    (cls_a),
  .cls_b    (cls_b),
  .rel      (rel),
  .truth    (truth),
  .sig_qnan (sig_qnan)
);

// File: tb/fp64_pred_cmp_tb.sv
module fp64_pred_cmp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [7:0]  pred_imm = '0;
  logic        result;
  logic        invalid;
  logic        denormal;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  fp64_pred_cmp u_dut (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .pred_imm (pred_imm),
    .result   (result),
    .invalid  (invalid),
    .denormal (denormal)
  );

  localparam int NV = 15;
  logic [63:0] vals [NV] = '{
    64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000,
    64'h3FF0_0000_0000_0000, 64'hBFF0_0000_0000_0000,
    64'h4000_0000_0000_0000, 64'hC000_0000_0000_0000,
    64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001,
    64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
    64'h7FF8_0000_0000_0000, 64'hFFF8_0000_0000_0001,
    64'h7FF0_0000_0000_0001, 64'h7FEF_FFFF_FFFF_FFFF,
    64'h3FF0_0000_0000_0001
  };

  // Outcomes per code 0..15 as {gt, lt, eq, un}.
  logic [3:0] tt [16] = '{
    4'b0010, 4'b0100, 4'b0110, 4'b0001, 4'b1101, 4'b1011, 4'b1001, 4'b1110,
    4'b0011, 4'b0101, 4'b0111, 4'b0000, 4'b1100, 4'b1010, 4'b1000, 4'b1111
  };
  localparam logic [31:0] SIG_MASK = 32'h9999_6666;

  function automatic bit is_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction
  function automatic bit is_sub(input logic [63:0] x);
    return (x[62:52] == 0) && (x[51:0] != 0);
  endfunction

  // 0 gt, 1 lt, 2 eq, 3 unordered
  function automatic int rel_of(input logic [63:0] a, input logic [63:0] b);
    real ra, rb;
    if (is_nan(a) || is_nan(b)) return 3;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra > rb) return 0;
    if (ra < rb) return 1;
    return 2;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h imm=%h actual=%0b expected=%0b",
               tag, opnd_a, opnd_b, pred_imm, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [7:0] imm);
    @(negedge clk);
    opnd_a   = a;
    opnd_b   = b;
    pred_imm = imm;
    #1;
  endtask

  task automatic full_check(input logic [63:0] a, input logic [63:0] b, input logic [7:0] imm);
    int r;
    logic [4:0] code;
    logic [3:0] row;
    logic exp_res, exp_inv;
    bit snan, qnan;
    apply(a, b, imm);
    code = imm[4:0];
    r    = rel_of(a, b);
    row  = tt[code[3:0]];
    exp_res = row[3 - r];
    snan = (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]);
    qnan = (is_nan(a) && a[51]) || (is_nan(b) && b[51]);
    exp_inv = snan || (qnan && SIG_MASK[code]);
    if (r == 3)           check("R2 result", result, exp_res);
    else if (code[4])     check("R5 result", result, exp_res);
    else                  check("R4/R3 result", result, exp_res);
    if (snan)             check("R7 invalid", invalid, exp_inv);
    else if (qnan)        check("R8 R6 invalid", invalid, exp_inv);
    else                  check("R9 invalid", invalid, exp_inv);
    check("R10 denormal", denormal, is_sub(a) || is_sub(b));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Start state: +0 vs +0 under code 0 is equal, no flags.
    apply(64'd0, 64'd0, 8'h00);
    check("R3 start result", result, 1'b1);
    check("R9 start invalid", invalid, 1'b0);
    check("R10 start denormal", denormal, 1'b0);

    // R1: reserved bits rotate through every value with a fixed code.
    for (int h = 0; h < 8; h++) begin
      apply(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, {h[2:0], 5'd1});
      check("R1 lt result", result, 1'b1);
      apply(64'h7FF8_0000_0000_0000, 64'd1, {h[2:0], 5'd0});
      check("R1 quiet invalid", invalid, 1'b0);
      check("R1 denormal", denormal, 1'b1);
    end

    // R11: infinity ordering and self-equality.
    apply(64'hFFF0_0000_0000_0000, 64'hFFEF_FFFF_FFFF_FFFF, 8'h01);
    check("R11 -inf below", result, 1'b1);
    apply(64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 8'h00);
    check("R11 +inf equal", result, 1'b1);

    // R6/R8 with quiet NaN: signaling vs quiet code at same truth.
    apply(64'h7FF8_0000_0000_0000, 64'd0, 8'h01);
    check("R6 signaling LT invalid", invalid, 1'b1);
    apply(64'h7FF8_0000_0000_0000, 64'd0, 8'h11);
    check("R6 quiet LT invalid", invalid, 1'b0);

    // Sweep all pairs and all codes, rotating reserved bits.
    for (int i = 0; i < NV; i++)
      for (int j = 0; j < NV; j++)
        for (int c = 0; c < 32; c++) begin
          logic [2:0] hi;
          hi = 3'((i * 3 + j + c) % 8);
          full_check(vals[i], vals[j], {hi, 5'(c)});
        end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule